// File: doc/BRIEF.md
# Framed-Word Asynchronous Serial Transmitter

This block produces an asynchronous serial line from a word-shifting transmit engine. Bytes are written into a small transmit queue. At each internal frame pulse the engine takes the oldest byte and wraps it into an 11-bit word. The word holds a leading high filler bit, a low start bit, the eight data bits with the least significant first, and a high stop bit. It shifts the word out at one bit per bit period. Frame pulses recur on a fixed period of 13 bit periods, so the line always rests high for at least two bit periods between bytes.

Software sets the baud rate with a divider value. It fills the queue, either before or after enabling, and watches the queue-full flag while filling. Before it turns the transmitter off, it waits until both the queue-empty flag and the shifter-busy flag show that the line is quiet. Two sticky error flags record a write to a full queue and a frame pulse that found no byte. A clear input resets both flags.

Top module: `fwuart_tx`

## Requirements
- R1: One bit period lasts exactly 2*(div+1) system clock cycles.
- R2: Each byte goes out on the line as a low start bit, then data bits 0 through 7 in that order, then a high stop bit. A high filler bit of one period comes before the start bit.
- R3: While bytes are waiting, successive start-bit falling edges are exactly 13 bit periods apart.
- R4: After enable, the first start-bit falling edge comes between 15 and 17 bit periods later. This covers a ready delay of two bit periods, then one 13-period frame interval, then the filler bit.
- R5: The queue holds 8 bytes and `full` is high when it holds 8. A write while `full` is high sets `ovf` and the byte is dropped.
- R6: A frame pulse that finds the queue empty while enabled sets `unf`. While disabled, `unf` is never set.
- R7: `hold_empty` rises as soon as the last byte is taken into the shifter, while `busy` is still high for that byte.
- R8: When `en` is low, the line is high and `busy` is low from the next cycle on. Bytes still in the queue are kept and are sent after the next enable.
- R9: A pulse on `err_clr` clears `ovf` and `unf`.
- R10: After reset the line is high, the queue is empty, and `busy`, `full`, `ovf` and `unf` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Transmitter enable |
| div | input | DIV_W | Bit-period divider value |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 8 | Byte to queue |
| err_clr | input | 1 | Clears both sticky error flags |
| full | output | 1 | Queue holds 8 bytes |
| hold_empty | output | 1 | Queue holds no byte |
| busy | output | 1 | Shifter is sending a word |
| txd | output | 1 | Serial line, idles high |
| ovf | output | 1 | Sticky: write to a full queue |
| unf | output | 1 | Sticky: frame pulse with an empty queue while enabled |

## Verification
The hardest case to reach is a disable that arrives while a word is in the shifter and another byte is still queued. The stimulus queues two bytes and enables the transmitter. It waits for `busy` to rise and then drops `en` inside the high filler bit, so no start edge ever appears on the line. The bench then checks that the line is high, that the second byte is still held, and that after re-enabling only the second byte comes out on the line. The scoreboard check on decoded bytes also shows that the 9th write of an overfilled queue never reaches the line.

// File: rtl/fwuart_tx.sv
module fwuart_tx #(
  parameter int DIV_W       = 16,
  parameter int DEPTH       = 8,
  parameter int FS_DIV      = 12,
  parameter int READY_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             err_clr,
  output logic             full,
  output logic             hold_empty,
  output logic             busy,
  output logic             txd,
  output logic             ovf,
  output logic             unf
);
  localparam int PW = DIV_W + 1;
  localparam int AW = $clog2(DEPTH);
  localparam int FW = $clog2(FS_DIV + 1);
  localparam int RW = $clog2(READY_TICKS + 1);
  localparam int WORD_W = 11;

  logic [PW-1:0]     pre;
  logic [RW-1:0]     rdy;
  logic [FW-1:0]     fcnt;
  logic [WORD_W-1:0] sh;
  logic [3:0]        bcnt;
  logic [7:0]        mem [DEPTH];
  logic [AW:0]       wp, rp;

  wire [PW-1:0] lim   = {div, 1'b1};
  wire          tick  = en && (pre == lim);
  wire          ready = (rdy == RW'(READY_TICKS));
  wire          fsync = tick && ready && (fcnt == FW'(FS_DIV));
  wire          push  = wr_en && !full;
  wire          pop   = fsync && !hold_empty;

  assign hold_empty = (wp == rp);
  assign full       = (wp[AW-1:0] == rp[AW-1:0]) && (wp[AW] != rp[AW]);
  assign busy       = (bcnt != 4'd0);
  assign txd        = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre  <= '0;
      rdy  <= '0;
      fcnt <= '0;
    end else if (!en) begin
      pre  <= '0;
      rdy  <= '0;
      fcnt <= '0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) begin
        if (!ready)     rdy  <= rdy + 1'b1;
        else if (fsync) fcnt <= '0;
        else            fcnt <= fcnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh   <= '1;
      bcnt <= '0;
    end else if (!en) begin
      bcnt <= '0;
    end else if (pop) begin
      sh   <= {1'b1, mem[rp[AW-1:0]], 1'b0, 1'b1};
      bcnt <= 4'(WORD_W);
    end else if (tick && busy) begin
      sh   <= {1'b1, sh[WORD_W-1:1]};
      bcnt <= bcnt - 1'b1;
    end

  always_ff @(posedge clk)
    if (push) mem[wp[AW-1:0]] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      ovf <= (ovf && !err_clr) || (wr_en && full);
      unf <= (unf && !err_clr) || (fsync && hold_empty);
    end
endmodule

module fwuart_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic wr_en,
  input logic err_clr,
  input logic full,
  input logic hold_empty,
  input logic busy,
  input logic txd,
  input logic ovf,
  input logic unf
);
  // R8
  disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (txd && !busy));
  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> ovf);
  // R5
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && hold_empty));
  // R2
  idle_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> txd);
  // R6
  unf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unf) |-> ($past(en) && hold_empty));
  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !wr_en && !en) |=> (!ovf && !unf));
endmodule

bind fwuart_tx fwuart_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .err_clr(err_clr),
  .full(full), .hold_empty(hold_empty), .busy(busy), .txd(txd),
  .ovf(ovf), .unf(unf)
);

// File: tb/fwuart_tx_tb.sv
module fwuart_tx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] div = 16'd1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        err_clr = 1'b0;
  logic        full, hold_empty, busy, txd, ovf, unf;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int p = 4;
  int nframes = 0;
  int falls[$];
  logic [7:0] expq[$];

  fwuart_tx u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .div(div), .wr_en(wr_en),
    .wr_data(wr_data), .err_clr(err_clr), .full(full),
    .hold_empty(hold_empty), .busy(busy), .txd(txd), .ovf(ovf), .unf(unf)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input logic expect_out);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
    if (expect_out) expq.push_back(b);
  endtask

  task automatic wait_frames(input int n);
    int t = 0;
    while (nframes < n && t < 30000) begin
      @(negedge clk);
      t++;
    end
    chk(nframes >= n, "R2 frames seen", nframes, n);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin : monitor
    logic prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && prev && !txd) begin
        logic [7:0] got;
        logic sb, pb;
        falls.push_back(cyc);
        repeat (p / 2) @(negedge clk);
        sb = txd;
        for (int i = 0; i < 8; i++) begin
          repeat (p) @(negedge clk);
          got[i] = txd;
        end
        repeat (p) @(negedge clk);
        pb = txd;
        chk(sb == 1'b0, "R2 start bit", sb, 0);
        chk(pb == 1'b1, "R2 stop bit", pb, 1);
        if (expq.size() == 0) begin
          chk(1'b0, "R5 unexpected byte", got, -1);
        end else begin
          logic [7:0] e;
          e = expq.pop_front();
          chk(got == e, "R2 data byte", got, e);
        end
        nframes++;
      end
      prev = txd;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin : stim
    int en_cyc, n, base, t;
    repeat (3) @(negedge clk);
    // R10
    chk(txd == 1'b1, "R10 txd idle", txd, 1);
    chk(hold_empty == 1'b1 && full == 1'b0, "R10 queue empty", full, 0);
    chk(busy == 1'b0 && ovf == 1'b0 && unf == 1'b0, "R10 flags low", {busy, ovf, unf}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    p = 4; div = 16'd1;
    put(8'h01, 1'b1);
    put(8'hA5, 1'b1);
    falls.delete();
    @(negedge clk);
    en = 1'b1;
    en_cyc = cyc;
    while (txd) @(negedge clk);
    chk(cyc - en_cyc >= 15 * p && cyc - en_cyc <= 17 * p, "R4 first frame latency",
        cyc - en_cyc, 16 * p);
    n = 0;
    while (!txd) begin
      n++;
      @(negedge clk);
    end
    chk(n == p, "R1 start bit length div=1", n, p);
    t = 0;
    while (falls.size() < 2 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    @(negedge clk);
    // R7
    chk(hold_empty && busy, "R7 hold empty while shifting", {hold_empty, busy}, 3);
    if (falls.size() >= 2)
      chk(falls[1] - falls[0] == 13 * p, "R3 frame spacing", falls[1] - falls[0], 13 * p);
    else
      chk(1'b0, "R3 frame spacing", falls.size(), 2);
    wait_frames(2);
    repeat (30 * p) @(negedge clk);
    chk(unf == 1'b1, "R6 underflow while enabled", unf, 1);

    en = 1'b0;
    @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk(!unf && !ovf, "R9 flags cleared", {ovf, unf}, 0);

    for (int i = 0; i < 8; i++) put(8'(8'h30 + 8'(i * 37)), 1'b1);
    chk(full == 1'b1, "R5 full after 8 writes", full, 1);
    chk(ovf == 1'b0, "R5 no overflow yet", ovf, 0);
    put(8'hEE, 1'b0);
    chk(ovf == 1'b1, "R5 overflow on 9th write", ovf, 1);
    repeat (200) @(negedge clk);
    chk(unf == 1'b0, "R6 no underflow while disabled", unf, 0);

    p = 8; div = 16'd3;
    base = nframes;
    falls.delete();
    @(negedge clk);
    en = 1'b1;
    wait_frames(base + 8);
    chk(falls.size() >= 2 && falls[1] - falls[0] == 13 * p, "R3 frame spacing div=3",
        falls.size() >= 2 ? falls[1] - falls[0] : 0, 13 * p);
    repeat (30 * p) @(negedge clk);
    chk(nframes == base + 8, "R5 dropped byte never sent", nframes - base, 8);
    chk(expq.size() == 0, "R2 all bytes delivered", expq.size(), 0);

    en = 1'b0;
    @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    put(8'h3C, 1'b0);
    put(8'h81, 1'b1);
    base = nframes;
    en = 1'b1;
    t = 0;
    while (!busy && t < 5000) begin
      @(negedge clk);
      t++;
    end
    en = 1'b0;
    repeat (2) @(negedge clk);
    chk(txd == 1'b1 && busy == 1'b0, "R8 disable quiets line", {txd, busy}, 2);
    chk(hold_empty == 1'b0, "R8 queue kept on disable", hold_empty, 0);
    repeat (4 * p) @(negedge clk);
    chk(nframes == base, "R8 no frame after mid-word disable", nframes - base, 0);
    en = 1'b1;
    wait_frames(base + 1);
    repeat (30 * p) @(negedge clk);
    chk(nframes == base + 1 && expq.size() == 0, "R8 held byte sent after re-enable",
        nframes - base, 1);
    finish_run();
  end
endmodule